// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a clock synthesiser through a safe reconfiguration. A requester presents a ready-made multiplier word with a one-cycle start pulse. The sequencer then uses a single register port to reach the synthesiser's registers. First it reads the control register, so that the unrelated control bits are kept. It then powers the synthesiser down and forces its bypass, input-direct, output-direct and output-enable bits to zero. Next it loads the multiplier word and the fixed divide-by-one divider word, and then powers the synthesiser back up.

After power-up the sequencer waits a fixed number of microsecond ticks and samples the lock flag. It repeats the wait and the sample a bounded number of times. When lock is seen, it sets output enable in a last control write and pulses done. If lock never comes, it pulses error and leaves output enable cleared. The time base is a tick input that is high for one cycle per microsecond, so a fast tick compresses the whole wait.

The register port is a valid/ready request channel. The sequencer holds `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until `req_ready` is seen high at a clock edge. That edge completes the access, and on a read `rsp_rdata` is sampled at the same edge. The target may hold `req_ready` low for any number of cycles, and the sequencer makes no progress meanwhile. The channel carries at most one access per cycle.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `busy`, `done`, `error` and `req_valid` are all 0.
- R2: A start pulse while idle first reads the control register (address 1). The next access is a control write equal to the value read, with bit 0 (power-down) set and bits 1 to 4 (bypass, input-direct, output-direct, output-enable) cleared. All other bits are kept.
- R3: The next two accesses are a write of the latched multiplier word to address 2, then a write of 0x00302062 to the divider register at address 3.
- R4: The next access is a control write equal to the value read with bits 0 to 4 all cleared.
- R5: After that write, the sequencer waits POLL_TICKS (default 10) rising ticks and then reads the status register at address 0, where bit 0 is the lock flag. It makes at most MAX_POLLS (default 4) such reads.
- R6: When a status read returns lock, the next access is a control write equal to the value read with bits 0 to 3 cleared and bit 4 (output-enable) set. The sequencer then pulses `done`.
- R7: When MAX_POLLS status reads all return no lock, the sequencer pulses `error` and makes no further write, so output-enable stays cleared.
- R8: A start pulse while `busy` is 1 is ignored, and the latched multiplier word is not changed.
- R9: `done` and `error` are each high for exactly one cycle per sequence and are never high together.
- R10: While `req_valid` is high and `req_ready` is low, the request fields stay stable, and no access completes without `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to reprogram |
| mult_word | input | DATA_W | Encoded multiplier word with bandwidth fields, latched at start |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse on lock and enable |
| error | output | 1 | One-cycle pulse when lock never arrives |
| us_tick | input | 1 | High one cycle per microsecond |
| req_valid | output | 1 | Register access request |
| req_ready | input | 1 | Access accepted at this edge |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 2 | 0 status, 1 control, 2 multiplier, 3 divider |
| req_wdata | output | DATA_W | Write data |
| rsp_rdata | input | DATA_W | Read data, valid with req_ready |

## Verification
On every cycle the assertions check four things. Request fields must hold under back-pressure. Done and error must be single-cycle pulses that never coincide. Every power-down control write must have the bypass, direct and enable bits cleared, and every divider write must carry the divide-by-one word. Done must follow directly after an accepted control write that sets output enable. The access order, the preserved control bits, the poll spacing in ticks, the retry bound, the failure path and the ignored mid-sequence start are only visible in the bench's scenarios. There a model synthesiser locks after a chosen delay, and the bench records every completed access.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_WR_PD, S_WR_MUL, S_WR_DIV,
    S_WR_PU, S_WAIT, S_RD_STAT, S_WR_EN
  } seq_state_e;

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MUL  = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  localparam int BIT_PD   = 0;
  localparam int BIT_BYP  = 1;
  localparam int BIT_DIN  = 2;
  localparam int BIT_DOUT = 3;
  localparam int BIT_EN   = 4;
endpackage

// File: rtl/pllseq_tick_timer.sv
module pllseq_tick_timer #(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  logic [CW-1:0] cnt;

  assign expired = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || expired)   cnt <= '0;
    else if (tick)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pllseq_try_counter.sv
module pllseq_try_counter #(
  parameter int MAX_TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_TRIES - 1);
  logic [CW-1:0] cnt;

  assign last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (bump)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pllseq_cmd.sv
module pllseq_cmd
  import pllseq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] DIV_WORD = 32'h0030_2062
) (
  input  seq_state_e        state,
  input  logic [DATA_W-1:0] ctrl_img,
  input  logic [DATA_W-1:0] mult_img,
  output logic              valid,
  output logic              write,
  output logic [1:0]        addr,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [DATA_W-1:0] M_PD   = DATA_W'(1) << BIT_PD;
  localparam logic [DATA_W-1:0] M_EN   = DATA_W'(1) << BIT_EN;
  localparam logic [DATA_W-1:0] M_PATH = (DATA_W'(1) << BIT_BYP) |
                                         (DATA_W'(1) << BIT_DIN) |
                                         (DATA_W'(1) << BIT_DOUT);
  localparam logic [DATA_W-1:0] M_ALL  = M_PD | M_EN | M_PATH;

  logic [DATA_W-1:0] ctrl_clean;
  assign ctrl_clean = ctrl_img & ~M_ALL;

  always_comb begin
    valid = 1'b1;
    write = 1'b1;
    addr  = ADDR_CTRL;
    wdata = '0;
    case (state)
      S_RD_CTRL: begin write = 1'b0; addr = ADDR_CTRL; end
      S_WR_PD:   wdata = ctrl_clean | M_PD;
      S_WR_MUL:  begin addr = ADDR_MUL; wdata = mult_img; end
      S_WR_DIV:  begin addr = ADDR_DIV; wdata = DIV_WORD; end
      S_WR_PU:   wdata = ctrl_clean;
      S_RD_STAT: begin write = 1'b0; addr = ADDR_STAT; end
      S_WR_EN:   wdata = ctrl_clean | M_EN;
      default:   begin valid = 1'b0; write = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pllseq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int POLL_TICKS = 10,
  parameter int MAX_POLLS  = 4,
  parameter logic [DATA_W-1:0] DIV_WORD = 32'h0030_2062
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] mult_word,
  output logic              busy,
  output logic              done,
  output logic              error,
  input  logic              us_tick,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [1:0]        req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rsp_rdata
);
  seq_state_e        state;
  logic [DATA_W-1:0] ctrl_q, mult_q;
  logic              done_q, err_q;
  logic              hs, wait_over, last_try, locked;

  assign hs     = req_valid && req_ready;
  assign locked = rsp_rdata[0];
  assign busy   = (state != S_IDLE);
  assign done   = done_q;
  assign error  = err_q;

  pllseq_cmd #(.DATA_W(DATA_W), .DIV_WORD(DIV_WORD)) cmd_i (
    .state(state), .ctrl_img(ctrl_q), .mult_img(mult_q),
    .valid(req_valid), .write(req_write), .addr(req_addr), .wdata(req_wdata)
  );

  pllseq_tick_timer #(.TICKS(POLL_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(state == S_WAIT),
    .tick(us_tick), .expired(wait_over)
  );

  pllseq_try_counter #(.MAX_TRIES(MAX_POLLS)) tries_i (
    .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE),
    .bump(state == S_RD_STAT && hs), .last(last_try)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ctrl_q <= '0;
      mult_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mult_q <= mult_word;
          state  <= S_RD_CTRL;
        end
        S_RD_CTRL: if (hs) begin
          ctrl_q <= rsp_rdata;
          state  <= S_WR_PD;
        end
        S_WR_PD:  if (hs) state <= S_WR_MUL;
        S_WR_MUL: if (hs) state <= S_WR_DIV;
        S_WR_DIV: if (hs) state <= S_WR_PU;
        S_WR_PU:  if (hs) state <= S_WAIT;
        S_WAIT:   if (wait_over) state <= S_RD_STAT;
        S_RD_STAT: if (hs) begin
          if (locked)        state <= S_WR_EN;
          else if (last_try) begin
            state <= S_IDLE;
            err_q <= 1'b1;
          end else           state <= S_WAIT;
        end
        S_WR_EN: if (hs) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] DIV_WORD = 32'h0030_2062
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic              error
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_pd_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd1 && req_wdata[0])
      |-> (req_wdata[4:1] == 4'b0000));

  p_div_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd3) |-> (req_wdata == DIV_WORD));

  p_done_after_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(req_valid && req_ready && req_write &&
                          req_addr == 2'd1 && req_wdata[4] && !req_wdata[0]));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.DATA_W(DATA_W), .DIV_WORD(DIV_WORD)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .done(done), .error(error)
);

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DIV1 = 32'h0030_2062;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] mult_word = '0;
  logic busy, done, error, us_tick, req_valid, req_ready, req_write;
  logic [1:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  // tick generator: one tick every 3 cycles
  logic [1:0] tdiv = '0;
  assign us_tick = (tdiv == 2'd2);
  always @(posedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;

  // model synthesiser
  logic [31:0] ctrl_m, mul_m, div_m;
  int lock_delay = 0, stall_cfg = 0, stall_cnt = 0, lock_cnt = 0;
  logic lock_m;
  assign lock_m    = (lock_cnt >= lock_delay);
  assign req_ready = req_valid && (stall_cnt >= stall_cfg);
  always_comb begin
    case (req_addr)
      2'd0:    rsp_rdata = {31'b0, lock_m};
      2'd1:    rsp_rdata = ctrl_m;
      2'd2:    rsp_rdata = mul_m;
      default: rsp_rdata = div_m;
    endcase
  end

  // access log
  logic [1:0]  lg_addr [32];
  logic        lg_wr   [32];
  logic [31:0] lg_data [32];
  int lg_n = 0, done_cyc = 0, err_cyc = 0, hold_viol = 0;
  int tick_total = 0, tick_at_pu = 0, tick_first_poll = -1;
  logic        pend = 1'b0;
  logic [1:0]  pend_addr;
  logic [31:0] pend_data;

  always @(posedge clk) begin
    if (us_tick) tick_total <= tick_total + 1;
    if (ctrl_m[0]) lock_cnt <= 0;
    else if (us_tick) lock_cnt <= lock_cnt + 1;
    if (req_valid && !req_ready) stall_cnt <= stall_cnt + 1;
    else stall_cnt <= 0;
    if (done) done_cyc <= done_cyc + 1;
    if (error) err_cyc <= err_cyc + 1;
    if (pend && (!req_valid || req_addr != pend_addr || req_wdata != pend_data))
      hold_viol <= hold_viol + 1;
    pend <= req_valid && !req_ready;
    pend_addr <= req_addr;
    pend_data <= req_wdata;
    if (req_valid && req_ready) begin
      if (lg_n < 32) begin
        lg_addr[lg_n] <= req_addr;
        lg_wr[lg_n]   <= req_write;
        lg_data[lg_n] <= req_write ? req_wdata : rsp_rdata;
      end
      lg_n <= lg_n + 1;
      if (req_write && req_addr == 2'd1 && req_wdata[4:0] == 5'd0)
        tick_at_pu <= tick_total + (us_tick ? 1 : 0);
      if (!req_write && req_addr == 2'd0 && tick_first_poll < 0)
        tick_first_poll <= tick_total + (us_tick ? 1 : 0);
      if (req_write) begin
        case (req_addr)
          2'd1: ctrl_m <= req_wdata;
          2'd2: mul_m  <= req_wdata;
          2'd3: div_m  <= req_wdata;
          default: ;
        endcase
      end
    end
  end

  pll_reprog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mult_word(mult_word),
    .busy(busy), .done(done), .error(error), .us_tick(us_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic prepare(input logic [31:0] ctrl0, input int dly, input int stall);
    @(negedge clk);
    ctrl_m = ctrl0; mul_m = '0; div_m = '0;
    lock_delay = dly; stall_cfg = stall;
    lg_n = 0; done_cyc = 0; err_cyc = 0; hold_viol = 0; tick_first_poll = -1;
  endtask

  task automatic launch(input logic [31:0] w);
    @(negedge clk);
    mult_word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mult_word = 32'hDEAD_BEEF;
  endtask

  task automatic finish_wait;
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  // compare log with the expected access list
  task automatic check_trace(input string tag, input logic [31:0] ctrl0,
                             input logic [31:0] w, input int polls, input bit ok);
    logic [1:0]  ea [32];
    logic        ew [32];
    logic [31:0] ed [32];
    logic [31:0] base;
    int n = 0;
    base = ctrl0 & ~32'h1F;
    ea[n] = 2'd1; ew[n] = 0; ed[n] = ctrl0;      n++;
    ea[n] = 2'd1; ew[n] = 1; ed[n] = base | 1;   n++;
    ea[n] = 2'd2; ew[n] = 1; ed[n] = w;          n++;
    ea[n] = 2'd3; ew[n] = 1; ed[n] = DIV1;       n++;
    ea[n] = 2'd1; ew[n] = 1; ed[n] = base;       n++;
    for (int i = 0; i < polls; i++) begin
      ea[n] = 2'd0; ew[n] = 0; ed[n] = (ok && i == polls-1) ? 32'd1 : 32'd0; n++;
    end
    if (ok) begin ea[n] = 2'd1; ew[n] = 1; ed[n] = base | 32'h10; n++; end
    chk({tag, " access count R5 R7"}, lg_n, n);
    for (int i = 0; i < n && i < lg_n; i++) begin
      chk($sformatf("%s access %0d addr R2 R3 R4", tag, i), {30'b0, lg_addr[i]}, {30'b0, ea[i]});
      chk($sformatf("%s access %0d dir", tag, i), {31'b0, lg_wr[i]}, {31'b0, ew[i]});
      chk($sformatf("%s access %0d data R2 R3 R4 R6", tag, i), lg_data[i], ed[i]);
    end
    chk({tag, " done cycles R6 R9"}, done_cyc, ok ? 1 : 0);
    chk({tag, " error cycles R7 R9"}, err_cyc, ok ? 0 : 1);
    chk({tag, " final ctrl enable R6 R7"}, {31'b0, ctrl_m[4]}, {31'b0, ok});
    chk({tag, " request hold R10"}, hold_viol, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("reset busy R1", {31'b0, busy}, 0);
    chk("reset done R1", {31'b0, done}, 0);
    chk("reset error R1", {31'b0, error}, 0);
    chk("reset req_valid R1", {31'b0, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_lock_third;
    prepare(32'hA5A0_001E, 25, 0);
    launch(32'h0BE1_8003);
    finish_wait();
    check_trace("lock3", 32'hA5A0_001E, 32'h0BE1_8003, 3, 1);
    chk("lock3 first poll tick gap R5", tick_first_poll - tick_at_pu, 10);
    chk("lock3 divider reg R3", div_m, DIV1);
  endtask

  task automatic t_lock_first;
    prepare(32'h0000_0F00, 5, 0);
    launch(32'h0012_3456);
    finish_wait();
    check_trace("lock1", 32'h0000_0F00, 32'h0012_3456, 1, 1);
  endtask

  task automatic t_lock_last;
    prepare(32'hFFFF_FFFF, 35, 0);
    launch(32'h7FFF_FFFF);
    finish_wait();
    check_trace("lock4", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4, 1);
  endtask

  task automatic t_no_lock;
    prepare(32'h1234_5610, 100, 0);
    launch(32'h0001_0003);
    finish_wait();
    check_trace("nolock", 32'h1234_5610, 32'h0001_0003, 4, 0);
  endtask

  task automatic t_backpressure;
    prepare(32'h0000_0008, 5, 3);
    launch(32'h00AB_CDEF);
    finish_wait();
    check_trace("stall", 32'h0000_0008, 32'h00AB_CDEF, 1, 1);
  endtask

  task automatic t_busy_start;
    prepare(32'h0000_0002, 25, 1);
    launch(32'h0055_AA55);
    repeat (6) @(negedge clk);
    chk("busy during run R8", {31'b0, busy}, 1);
    mult_word = 32'h0F0F_0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    mult_word = 32'h0F0F_0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait();
    check_trace("busystart R8", 32'h0000_0002, 32'h0055_AA55, 3, 1);
    chk("busystart multiplier kept R8", mul_m, 32'h0055_AA55);
    chk("busystart idle after R8", {31'b0, busy}, 0);
  endtask

  initial begin
    t_reset();
    t_lock_third();
    t_lock_first();
    t_lock_last();
    t_no_lock();
    t_backpressure();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule